// File: doc/BRIEF.md
# Critical-Range Request Tagger with Backup Redirect

This block sits on the master side of an on-chip network interface. It takes memory requests from a processor and turns each one into header fields: a destination node ID, a critical flag, and the request's address, direction and ID passed through unchanged. A request whose address lies inside a configurable window is critical. Critical data is also mirrored elsewhere in the system on a more robust backup memory.

Each read request is stored in a small outstanding table, indexed by its ID, together with the node it was sent to. When a read response arrives, the node that sent it is compared with the stored destination. A mismatch means the main memory has handed the read over to its backup.

Two policies control what happens on a mismatch. Under the permanent policy, a mismatch on a critical read moves all later critical requests straight to the backup node. Under the transient policy, every request keeps going to the main node. A sticky status bit records any mismatch. A clear input restores routing to the main node and clears the status bit.

Top module: `crit_redirect_ini`

## Requirements
- R1: `hdr_crit` is 1 exactly when `cfg_lo <= req_addr <= cfg_hi`, with both bounds inclusive. `hdr_addr`, `hdr_wr` and `hdr_id` equal the request fields in the same cycle.
- R2: A non-critical request is always sent to `cfg_main_node`, whatever the redirect state.
- R3: A critical request is sent to `cfg_main_node` while `redirect` is 0. It is sent to `cfg_bkp_node` while `redirect` is 1 and `cfg_transient` is 0.
- R4: With `cfg_transient` = 0, a response to an outstanding critical read whose `rsp_src` differs from the stored destination sets `redirect` from the next cycle on.
- R5: With `cfg_transient` = 1, every request is sent to `cfg_main_node`, and a mismatch never sets `redirect`.
- R6: `mismatch_seen` becomes 1 on the cycle after any response to an outstanding read with a mismatched source, critical or not. A response from the expected source leaves it unchanged.
- R7: A pulse on `clr_redirect` forces `redirect` and `mismatch_seen` to 0 on the next cycle. The clear wins over a mismatch in the same cycle.
- R8: In any cycle where `cfg_lo`, `cfg_hi`, `cfg_main_node` or `cfg_bkp_node` differs from its value in the previous cycle, `req_ready` and `hdr_valid` are 0.
- R9: A read (`req_wr` = 0) whose ID is still outstanding is held off, with `req_ready` = 0 and `hdr_valid` = 0, until the response for that ID has been taken.
- R10: A response whose ID has no outstanding read changes neither `redirect` nor `mismatch_seen`.
- R11: After reset, `redirect` and `mismatch_seen` are 0, no ID is outstanding, and `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lo | input | AW | Lowest critical address (inclusive) |
| cfg_hi | input | AW | Highest critical address (inclusive) |
| cfg_main_node | input | NW | Node ID of the main memory |
| cfg_bkp_node | input | NW | Node ID of the backup memory |
| cfg_transient | input | 1 | 1 selects the transient policy, 0 the permanent policy |
| clr_redirect | input | 1 | Clears the redirect and the mismatch status |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_addr | input | AW | Request address |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_id | input | IDW | Request ID |
| hdr_valid | output | 1 | Header valid |
| hdr_ready | input | 1 | Downstream can take a header |
| hdr_dest | output | NW | Destination node ID |
| hdr_crit | output | 1 | Critical flag |
| hdr_addr | output | AW | Address carried in the header |
| hdr_wr | output | 1 | Direction carried in the header |
| hdr_id | output | IDW | ID carried in the header |
| rsp_valid | input | 1 | Read response valid |
| rsp_ready | output | 1 | Response accepted (always 1) |
| rsp_id | input | IDW | ID of the response |
| rsp_src | input | NW | Node that sent the response |
| redirect | output | 1 | Critical traffic goes to the backup node |
| mismatch_seen | output | 1 | Sticky: a response came from an unexpected node |

## Verification
The header fields and both ready signals are combinational in the request and the configuration. The bench therefore checks them in the same cycle the stimulus is applied, after the inputs settle at the falling edge and before the next rising edge.

`redirect` and `mismatch_seen` are registers. The bench applies a response or a clear for one rising edge and reads these outputs just after that edge. This is also where it checks that nothing changed for an unknown ID or a matching source.

For the configuration-change stall, the new value and the request are applied together. The stall is checked in that cycle, and the request is checked again one edge later, when it goes through with the new window.

// File: rtl/crit_redirect_ini.sv
module crit_redirect_ini #(
  parameter int AW  = 32,
  parameter int NW  = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cfg_lo,
  input  logic [AW-1:0]  cfg_hi,
  input  logic [NW-1:0]  cfg_main_node,
  input  logic [NW-1:0]  cfg_bkp_node,
  input  logic           cfg_transient,
  input  logic           clr_redirect,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_wr,
  input  logic [IDW-1:0] req_id,
  output logic           hdr_valid,
  input  logic           hdr_ready,
  output logic [NW-1:0]  hdr_dest,
  output logic           hdr_crit,
  output logic [AW-1:0]  hdr_addr,
  output logic           hdr_wr,
  output logic [IDW-1:0] hdr_id,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [IDW-1:0] rsp_id,
  input  logic [NW-1:0]  rsp_src,
  output logic           redirect,
  output logic           mismatch_seen
);
  localparam int DEPTH = 1 << IDW;
  localparam int CW    = 2 * AW + 2 * NW;

  logic [CW-1:0]    cfg_now, cfg_prev;
  logic             cfg_chg, blocked, acc_rd, rsp_hit, rsp_bad;
  logic [DEPTH-1:0] busy, crit_t;
  logic [NW-1:0]    dest_t [DEPTH];

  assign cfg_now = {cfg_lo, cfg_hi, cfg_main_node, cfg_bkp_node};

  always_ff @(posedge clk) cfg_prev <= cfg_now;

  assign cfg_chg   = (cfg_now != cfg_prev);
  assign blocked   = cfg_chg | (!req_wr & busy[req_id]);
  assign hdr_valid = req_valid & !blocked;
  assign req_ready = hdr_ready & !blocked;
  assign acc_rd    = hdr_valid & hdr_ready & !req_wr;

  assign hdr_crit = (req_addr >= cfg_lo) && (req_addr <= cfg_hi);
  assign hdr_dest = (hdr_crit && redirect && !cfg_transient) ? cfg_bkp_node : cfg_main_node;
  assign hdr_addr = req_addr;
  assign hdr_wr   = req_wr;
  assign hdr_id   = req_id;

  assign rsp_ready = 1'b1;
  assign rsp_hit   = rsp_valid & busy[rsp_id];
  assign rsp_bad   = rsp_hit & (rsp_src != dest_t[rsp_id]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (acc_rd && req_id == IDW'(i)) busy[i] <= 1'b1;
        else if (rsp_hit && rsp_id == IDW'(i)) busy[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_rd) begin
      dest_t[req_id] <= hdr_dest;
      crit_t[req_id] <= hdr_crit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect      <= 1'b0;
      mismatch_seen <= 1'b0;
    end else if (clr_redirect) begin
      redirect      <= 1'b0;
      mismatch_seen <= 1'b0;
    end else if (rsp_bad) begin
      mismatch_seen <= 1'b1;
      if (crit_t[rsp_id] && !cfg_transient) redirect <= 1'b1;
    end
  end
endmodule

module crit_redirect_ini_chk #(
  parameter int AW = 32,
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cfg_lo,
  input logic [AW-1:0] cfg_hi,
  input logic [NW-1:0] cfg_main_node,
  input logic [NW-1:0] cfg_bkp_node,
  input logic          cfg_transient,
  input logic          clr_redirect,
  input logic          req_ready,
  input logic          hdr_valid,
  input logic          hdr_crit,
  input logic [NW-1:0] hdr_dest,
  input logic          redirect,
  input logic          mismatch_seen
);
  assert_noncrit_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_crit |-> hdr_dest == cfg_main_node);

  assert_crit_backup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_crit && redirect && !cfg_transient |-> hdr_dest == cfg_bkp_node);

  assert_redirect_policy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redirect) |-> !$past(cfg_transient));

  assert_transient_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && cfg_transient |-> hdr_dest == cfg_main_node);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_redirect |=> !redirect && !mismatch_seen);

  assert_cfg_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_lo, cfg_hi, cfg_main_node, cfg_bkp_node}) |-> !req_ready && !hdr_valid);
endmodule

bind crit_redirect_ini crit_redirect_ini_chk #(.AW(AW), .NW(NW)) chk_i (.*);

// File: tb/crit_redirect_ini_tb_top.sv
module crit_redirect_ini_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, NW = 4, IDW = 2;
  localparam logic [NW-1:0] MAIN = 4'd3, BKP = 4'd9;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_lo = 32'h1000, cfg_hi = 32'h1FFF;
  logic [NW-1:0] cfg_main_node = MAIN, cfg_bkp_node = BKP;
  logic cfg_transient = 0, clr_redirect = 0;
  logic req_valid = 0, req_wr = 0, hdr_ready = 1, rsp_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [IDW-1:0] req_id = '0, rsp_id = '0;
  logic [NW-1:0] rsp_src = '0;
  logic req_ready, hdr_valid, hdr_crit, hdr_wr, rsp_ready, redirect, mismatch_seen;
  logic [NW-1:0] hdr_dest;
  logic [AW-1:0] hdr_addr;
  logic [IDW-1:0] hdr_id;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crit_redirect_ini #(.AW(AW), .NW(NW), .IDW(IDW)) dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_req(input logic [AW-1:0] a, input logic w, input logic [IDW-1:0] id);
    @(negedge clk);
    req_addr = a; req_wr = w; req_id = id; req_valid = 1; #1;
  endtask

  task automatic end_req();
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic put_rsp(input logic [IDW-1:0] id, input logic [NW-1:0] src, input logic clr);
    @(negedge clk);
    rsp_id = id; rsp_src = src; rsp_valid = 1; clr_redirect = clr;
    @(posedge clk); #1 rsp_valid = 0; clr_redirect = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr_redirect = 1;
    @(posedge clk); #1 clr_redirect = 0;
  endtask

  task automatic t_reset();
    check("R11 redirect", redirect, 0);
    check("R11 mismatch_seen", mismatch_seen, 0);
    check("R11 rsp_ready", rsp_ready, 1);
  endtask

  task automatic t_range();
    put_req(32'h0FFF, 1, 2'd1);
    check("R1 below lo", hdr_crit, 0); check("R2 dest", hdr_dest, MAIN); end_req();
    put_req(32'h1000, 1, 2'd2);
    check("R1 at lo", hdr_crit, 1); check("R1 id pass", hdr_id, 2);
    check("R1 addr pass", hdr_addr, 32'h1000); check("R1 wr pass", hdr_wr, 1); end_req();
    put_req(32'h1FFF, 1, 2'd0);
    check("R1 at hi", hdr_crit, 1); check("R3 dest main", hdr_dest, MAIN); end_req();
    put_req(32'h2000, 1, 2'd0);
    check("R1 above hi", hdr_crit, 0); end_req();
  endtask

  task automatic t_unknown_rsp();
    put_rsp(2'd2, BKP, 0);
    check("R10 mismatch_seen", mismatch_seen, 0);
    check("R10 redirect", redirect, 0);
  endtask

  task automatic t_noncrit_mismatch();
    put_req(32'h0500, 0, 2'd0); check("R2 read dest", hdr_dest, MAIN); end_req();
    put_rsp(2'd0, MAIN, 0);
    check("R6 match no effect", mismatch_seen, 0);
    put_req(32'h0600, 0, 2'd1); end_req();
    put_rsp(2'd1, BKP, 0);
    check("R6 sticky set", mismatch_seen, 1);
    check("R4 noncrit no redirect", redirect, 0);
    pulse_clear();
    check("R7 clear status", mismatch_seen, 0);
  endtask

  task automatic t_busy_id();
    put_req(32'h1100, 0, 2'd2);
    check("R9 first accepted", req_ready, 1); end_req();
    put_req(32'h1104, 0, 2'd2);
    check("R9 busy ready", req_ready, 0); check("R9 busy valid", hdr_valid, 0);
    req_valid = 0;
    put_rsp(2'd2, MAIN, 0);
    put_req(32'h1104, 0, 2'd2);
    check("R9 freed ready", req_ready, 1); end_req();
    put_rsp(2'd2, MAIN, 0);
    check("R6 match after free", mismatch_seen, 0);
  endtask

  task automatic t_permanent();
    put_req(32'h1200, 0, 2'd3); check("R3 before redirect", hdr_dest, MAIN); end_req();
    put_rsp(2'd3, BKP, 0);
    check("R4 redirect set", redirect, 1);
    check("R6 sticky", mismatch_seen, 1);
    put_req(32'h1800, 1, 2'd0); check("R3 crit to backup", hdr_dest, BKP); end_req();
    put_req(32'h3000, 1, 2'd0); check("R2 noncrit while redirected", hdr_dest, MAIN); end_req();
  endtask

  task automatic t_clear_wins();
    put_req(32'h1300, 0, 2'd0); check("R3 read to backup", hdr_dest, BKP); end_req();
    put_rsp(2'd0, MAIN, 1);
    check("R7 redirect cleared", redirect, 0);
    check("R7 clear wins", mismatch_seen, 0);
    put_req(32'h1300, 1, 2'd0); check("R7 crit back to main", hdr_dest, MAIN); end_req();
  endtask

  task automatic t_transient();
    @(negedge clk); cfg_transient = 1;
    put_req(32'h1400, 0, 2'd1); end_req();
    put_rsp(2'd1, BKP, 0);
    check("R5 sticky", mismatch_seen, 1);
    check("R5 no redirect", redirect, 0);
    put_req(32'h1400, 1, 2'd0); check("R5 crit to main", hdr_dest, MAIN); end_req();
    pulse_clear();
    @(negedge clk); cfg_transient = 0;
  endtask

  task automatic t_cfg_change();
    @(negedge clk);
    cfg_hi = 32'h2FFF; req_addr = 32'h2000; req_wr = 1; req_id = 0; req_valid = 1; #1;
    check("R8 stall ready", req_ready, 0);
    check("R8 stall valid", hdr_valid, 0);
    @(posedge clk); @(negedge clk); #1;
    check("R8 resumes", req_ready, 1);
    check("R1 new window", hdr_crit, 1);
    end_req();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_range();
    t_unknown_rsp();
    t_noncrit_mismatch();
    t_busy_id();
    t_permanent();
    t_clear_wins();
    t_transient();
    t_cfg_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule